// File: doc/BRIEF.md
# NAND Flash Window Bridge

This block sits as a slave on a simple request/ready host bus. It turns byte reads and writes that fall inside a window of host addresses into NAND flash pin activity. No command or address registers exist for the flash. Low address bits of each window access decide which NAND control lines are raised while that access runs. Offset bit 2 raises the address latch line, bit 3 the command latch line, bit 4 chip select, bit 5 the spare-area line and bit 6 write protect. A driver therefore issues a command by writing the opcode byte at offset 0x18 (chip select with command latch), an address byte at offset 0x14 (chip select with address latch), and moves data at offset 0x10 (chip select alone).

Every enabled window access runs a fixed strobe sequence: an optional setup phase, a wait phase in which the active-low write or read strobe is low, a hold phase and a recovery phase. Each phase count is scaled by a clock multiplier. The host is stalled until the sequence ends. Two registers sit above the window (host address bit 7 set). The control register at 0xB0 enables the bridge, sets line polarities and routes the chip-select output and ready input. The status register at 0xB4 reports the ready/busy pin and a completion flag.

Top module: `nand_window_bridge`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0 when both ready pins are low, both write and read strobes are high, the data bus is not driven, and the address latch, command latch, chip-select, spare, write-protect and pre-charge pins are all low.
- R2: A write to offset 0xB0 stores only bits 0, 1, 4-7, 8, 10 and 20; reading 0xB0 returns the stored bits and zero elsewhere, so writing all ones reads back 0x001005F3.
- R3: When control bit 0 (NAND mode) or bit 20 (chip enable) is clear, a window access (host address bit 7 clear) completes with host_ready high in the cycle after it is accepted, moves no NAND pin and returns 0 on a read. A register access also completes in the cycle after acceptance.
- R4: During the setup, wait and hold phases of an enabled window access, access offset bits 2, 3, 4, 5 and 6 assert the address latch, command latch, chip-select, spare and write-protect lines respectively. Outside those phases the lines are deasserted.
- R5: An enabled access runs setup for SETUP_EN*CMULT cycles, then wait for RD_WAIT*CMULT (read) or WR_WAIT*CMULT (write) cycles, then hold for HOLD_CYC*CMULT and recovery for RECOV_CYC*CMULT cycles. host_ready is high for exactly the one cycle that follows recovery.
- R6: On a write, nand_we_n is low for the whole wait phase only. nand_dq_oe is high and nand_dq_out carries host_wdata[7:0] from setup through hold, and nand_dq_out is 0 when not driven.
- R7: On a read, nand_re_n is low for the whole wait phase only, the bus is never driven, and host_rdata[7:0] returns nand_dq_in as sampled in the last wait cycle, with upper bits 0.
- R8: Status bit 3 is a completion flag. It clears when an enabled window access is accepted, sets when that access's recovery phase ends, and is untouched by register or disabled accesses.
- R9: Status bit 0 reports nand_rb[0], or nand_rb[1] when control bit 8 is set.
- R10: Control bits 4, 5, 6 and 7 invert the pin level of chip select, spare, write protect and pre-charge respectively, both while idle and while asserted.
- R11: Control bit 10 routes the chip-select assertion to nand_cs[1] instead of nand_cs[0]. The unrouted pin stays at its deasserted level.
- R12: Control bit 1 keeps chip select asserted through the recovery phase as well. When it is clear, chip select drops at the end of hold.
- R13: The pre-charge line is asserted exactly during the setup phase of every enabled window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset; bit 7 clear selects the window |
| host_wdata | input | 32 | Write data (window uses bits 7:0) |
| host_rdata | output | 32 | Read data, valid with host_ready |
| host_ready | output | 1 | One-cycle access completion |
| nand_dq_in | input | 8 | Flash data bus input |
| nand_rb | input | 2 | Ready/busy inputs of both chip-select sets |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_cs | output | 2 | Chip-select outputs, one per set |
| nand_spare | output | 1 | Spare-area select |
| nand_wp | output | 1 | Write protect |
| nand_pre | output | 1 | Pre-charge, asserted in setup |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Flash data bus output |
| nand_dq_oe | output | 1 | Flash data bus output enable |

## Verification
The bench builds the bridge with the default timing: setup enabled, read and write wait of 2, hold and recovery of 1, and a multiplier of 4. Every phase therefore lasts several cycles (4, 8, 4, 4), so the phase counters must step through multi-cycle terms, and the last-wait sampling point differs from its neighbours because the bench changes the flash data input every cycle. With setup enabled, the pre-charge window and the setup-phase bus drive can be observed on their own. The bench then sweeps the polarity, routing and hold-through-recovery control bits over these same long phases.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_RECOV  = 3'd4,
    PH_DONE   = 3'd5
  } phase_e;

  typedef struct packed {
    logic ce;        // word bit 20
    logic cs_route;  // word bit 10
    logic rb_route;  // word bit 8
    logic pol_pre;   // word bit 7
    logic pol_wp;    // word bit 6
    logic pol_se;    // word bit 5
    logic pol_cs;    // word bit 4
    logic csmux;     // word bit 1
    logic nand_en;   // word bit 0
  } ctrl_t;

  localparam logic [7:0] OFS_CTRL = 8'hB0;
  localparam logic [7:0] OFS_STAT = 8'hB4;

  localparam int LINE_ALE = 2;
  localparam int LINE_CLE = 3;
  localparam int LINE_CS  = 4;
  localparam int LINE_SE  = 5;
  localparam int LINE_WP  = 6;

endpackage

// File: rtl/nwb_regs.sv
module nwb_regs
  import nwb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output ctrl_t       ctrl,
  output logic [31:0] ctrl_word
);

  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.ce       = wdata[20];
      ctrl_d.cs_route = wdata[10];
      ctrl_d.rb_route = wdata[8];
      ctrl_d.pol_pre  = wdata[7];
      ctrl_d.pol_wp   = wdata[6];
      ctrl_d.pol_se   = wdata[5];
      ctrl_d.pol_cs   = wdata[4];
      ctrl_d.csmux    = wdata[1];
      ctrl_d.nand_en  = wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;
  assign ctrl_word = {11'b0, ctrl_q.ce, 9'b0, ctrl_q.cs_route, 1'b0,
                      ctrl_q.rb_route, ctrl_q.pol_pre, ctrl_q.pol_wp,
                      ctrl_q.pol_se, ctrl_q.pol_cs, 2'b0, ctrl_q.csmux,
                      ctrl_q.nand_en};

endmodule

// File: rtl/nwb_seq.sv
module nwb_seq
  import nwb_pkg::*;
#(
  parameter int SETUP_LEN = 4,
  parameter int RD_LEN    = 8,
  parameter int WR_LEN    = 8,
  parameter int HOLD_LEN  = 4,
  parameter int RECOV_LEN = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_win,
  input  logic   start_reg,
  input  logic   is_wr_in,
  output phase_e phase,
  output logic   op_wr,
  output logic   last_wait,
  output logic   cmplt
);

  localparam int M1      = (SETUP_LEN > RD_LEN) ? SETUP_LEN : RD_LEN;
  localparam int M2      = (WR_LEN > HOLD_LEN) ? WR_LEN : HOLD_LEN;
  localparam int M3      = (M1 > M2) ? M1 : M2;
  localparam int MAX_LEN = (M3 > RECOV_LEN) ? M3 : RECOV_LEN;
  localparam int CW      = $clog2(MAX_LEN + 1) + 1;

  localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_LEN - 1);
  localparam logic [CW-1:0] RD_LAST    = CW'(RD_LEN - 1);
  localparam logic [CW-1:0] WR_LAST    = CW'(WR_LEN - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_LEN - 1);
  localparam logic [CW-1:0] RECOV_LAST = CW'(RECOV_LEN - 1);

  phase_e        state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          opwr_q, opwr_d;
  logic          cmplt_q, cmplt_d;
  logic [CW-1:0] wait_last;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    opwr_d    = opwr_q;
    cmplt_d   = cmplt_q;
    wait_last = opwr_q ? WR_LAST : RD_LAST;
    unique case (state_q)
      PH_IDLE: begin
        if (start_win) begin
          opwr_d  = is_wr_in;
          cmplt_d = 1'b0;
          if (SETUP_LEN > 0) begin
            state_d = PH_SETUP;
            cnt_d   = SETUP_LAST;
          end else begin
            state_d = PH_STROBE;
            cnt_d   = is_wr_in ? WR_LAST : RD_LAST;
          end
        end else if (start_reg) begin
          state_d = PH_DONE;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          state_d = PH_STROBE;
          cnt_d   = wait_last;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          state_d = PH_HOLD;
          cnt_d   = HOLD_LAST;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_HOLD: begin
        if (cnt_q == '0) begin
          state_d = PH_RECOV;
          cnt_d   = RECOV_LAST;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_RECOV: begin
        if (cnt_q == '0) begin
          state_d = PH_DONE;
          cmplt_d = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      opwr_q  <= 1'b0;
      cmplt_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opwr_q  <= opwr_d;
      cmplt_q <= cmplt_d;
    end
  end

  assign phase     = state_q;
  assign op_wr     = opwr_q;
  assign last_wait = (state_q == PH_STROBE) && (cnt_q == '0);
  assign cmplt     = cmplt_q;

endmodule

// File: rtl/nwb_pins.sv
module nwb_pins
  import nwb_pkg::*;
#(
  parameter int DQ_W   = 8,
  parameter int N_SETS = 2
) (
  input  phase_e            phase,
  input  logic              op_wr,
  input  logic [6:2]        lines,
  input  logic [DQ_W-1:0]   wbyte,
  input  ctrl_t             ctrl,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic [N_SETS-1:0] nand_cs,
  output logic              nand_spare,
  output logic              nand_wp,
  output logic              nand_pre,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DQ_W-1:0]   nand_dq_out,
  output logic              nand_dq_oe
);

  logic active, strobe, cs_on;

  always_comb begin
    active = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strobe = (phase == PH_STROBE);
    cs_on  = lines[LINE_CS] && (active || (ctrl.csmux && phase == PH_RECOV));
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_SETS; gi++) begin : g_cs
      assign nand_cs[gi] = (cs_on && (int'(ctrl.cs_route) == gi)) ^ ctrl.pol_cs;
    end
  endgenerate

  assign nand_ale    = active && lines[LINE_ALE];
  assign nand_cle    = active && lines[LINE_CLE];
  assign nand_spare  = (active && lines[LINE_SE]) ^ ctrl.pol_se;
  assign nand_wp     = (active && lines[LINE_WP]) ^ ctrl.pol_wp;
  assign nand_pre    = (phase == PH_SETUP) ^ ctrl.pol_pre;
  assign nand_we_n   = !(strobe && op_wr);
  assign nand_re_n   = !(strobe && !op_wr);
  assign nand_dq_oe  = active && op_wr;
  assign nand_dq_out = nand_dq_oe ? wbyte : '0;

endmodule

// File: rtl/nand_window_bridge.sv
module nand_window_bridge
  import nwb_pkg::*;
#(
  parameter int RD_WAIT   = 2,
  parameter int WR_WAIT   = 2,
  parameter int HOLD_CYC  = 1,
  parameter int RECOV_CYC = 1,
  parameter int SETUP_EN  = 1,
  parameter int CMULT     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [7:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_ready,
  input  logic [7:0]  nand_dq_in,
  input  logic [1:0]  nand_rb,
  output logic        nand_ale,
  output logic        nand_cle,
  output logic [1:0]  nand_cs,
  output logic        nand_spare,
  output logic        nand_wp,
  output logic        nand_pre,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_out,
  output logic        nand_dq_oe
);

  localparam int SETUP_LEN = (SETUP_EN != 0) ? CMULT : 0;
  localparam int RD_LEN    = RD_WAIT * CMULT;
  localparam int WR_LEN    = WR_WAIT * CMULT;
  localparam int HOLD_LEN  = HOLD_CYC * CMULT;
  localparam int RECOV_LEN = RECOV_CYC * CMULT;

  ctrl_t       ctrl;
  logic [31:0] ctrl_word, status_word;
  phase_e      phase;
  logic        op_wr, last_wait, cmplt;
  logic        accept, is_win, win_go, reg_go, ctrl_wr, rb_sel;
  logic [6:2]  lines_q, lines_d;
  logic [7:0]  wbyte_q, wbyte_d;
  logic [31:0] rdata_q, rdata_d;

  always_comb begin
    accept  = host_req && (phase == PH_IDLE);
    is_win  = !host_addr[7];
    win_go  = accept && is_win && ctrl.nand_en && ctrl.ce;
    reg_go  = accept && !win_go;
    ctrl_wr = accept && !is_win && host_we && (host_addr == OFS_CTRL);
    rb_sel  = ctrl.rb_route ? nand_rb[1] : nand_rb[0];
    status_word = {28'b0, cmplt, 2'b0, rb_sel};
  end

  nwb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(host_wdata),
    .ctrl(ctrl), .ctrl_word(ctrl_word)
  );

  nwb_seq #(
    .SETUP_LEN(SETUP_LEN), .RD_LEN(RD_LEN), .WR_LEN(WR_LEN),
    .HOLD_LEN(HOLD_LEN), .RECOV_LEN(RECOV_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_win(win_go), .start_reg(reg_go),
    .is_wr_in(host_we), .phase(phase), .op_wr(op_wr),
    .last_wait(last_wait), .cmplt(cmplt)
  );

  // captured access state: next-state logic with explicit enables
  always_comb begin
    lines_d = lines_q;
    wbyte_d = wbyte_q;
    rdata_d = rdata_q;
    if (win_go) begin
      lines_d = host_addr[6:2];
      wbyte_d = host_wdata[7:0];
    end
    if (accept) begin
      rdata_d = '0;
      if (!is_win && !host_we) begin
        unique case (host_addr)
          OFS_CTRL: rdata_d = ctrl_word;
          OFS_STAT: rdata_d = status_word;
          default:  rdata_d = '0;
        endcase
      end
    end else if (last_wait && !op_wr) begin
      rdata_d = {24'b0, nand_dq_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= '0;
      wbyte_q <= '0;
      rdata_q <= '0;
    end else begin
      lines_q <= lines_d;
      wbyte_q <= wbyte_d;
      rdata_q <= rdata_d;
    end
  end

  nwb_pins #(.DQ_W(8), .N_SETS(2)) u_pins (
    .phase(phase), .op_wr(op_wr), .lines(lines_q), .wbyte(wbyte_q),
    .ctrl(ctrl), .nand_ale(nand_ale), .nand_cle(nand_cle),
    .nand_cs(nand_cs), .nand_spare(nand_spare), .nand_wp(nand_wp),
    .nand_pre(nand_pre), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe)
  );

  assign host_ready = (phase == PH_DONE);
  assign host_rdata = rdata_q;

endmodule

// File: rtl/nwb_checker.sv
module nwb_checker (
  input logic clk,
  input logic rst_n,
  input logic host_ready,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic accept,
  input logic win_go,
  input logic cmplt
);

  assert_ready_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);

  assert_reg_quick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !win_go) |=> host_ready);

  assert_cmplt_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_go |=> !cmplt);

  assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_we_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe);

  assert_re_nodrive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

endmodule

bind nand_window_bridge nwb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready),
  .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe),
  .accept(accept), .win_go(win_go), .cmplt(cmplt)
);

// File: tb/sim_nand_window_bridge.sv
`timescale 1ns/1ps
module sim_nand_window_bridge;

  localparam int P_RD = 2, P_WR = 2, P_HOLD = 1, P_REC = 1, P_SEN = 1, P_MUL = 4;
  localparam int SL = P_SEN * P_MUL;
  localparam int HL = P_HOLD * P_MUL;
  localparam int RL = P_REC * P_MUL;

  logic        clk, rst_n, host_req, host_we, host_ready;
  logic [7:0]  host_addr, nand_dq_in, nand_dq_out;
  logic [31:0] host_wdata, host_rdata;
  logic [1:0]  nand_rb, nand_cs;
  logic nand_ale, nand_cle, nand_spare, nand_wp, nand_pre, nand_we_n, nand_re_n, nand_dq_oe;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] ctrl_m;
  bit cmplt_m;

  nand_window_bridge #(.RD_WAIT(P_RD), .WR_WAIT(P_WR), .HOLD_CYC(P_HOLD),
    .RECOV_CYC(P_REC), .SETUP_EN(P_SEN), .CMULT(P_MUL)) u0 (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_ready(host_ready), .nand_dq_in(nand_dq_in), .nand_rb(nand_rb),
    .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_cs(nand_cs),
    .nand_spare(nand_spare), .nand_wp(nand_wp), .nand_pre(nand_pre),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [18:0] exp_vec(int k, int t, bit en, bit wr, logic [6:0] a,
                                          logic [7:0] wb, logic [31:0] c);
    int ph;
    bit act, cson;
    logic [18:0] v;
    ph = 0;
    if (en && k >= 1 && k <= t) begin
      if (k <= SL) ph = 1;
      else if (k <= t - HL - RL) ph = 2;
      else if (k <= t - RL) ph = 3;
      else ph = 4;
    end
    act  = (ph >= 1 && ph <= 3);
    cson = a[4] && (act || (c[1] && ph == 4));
    v[18] = (k == t + 1);
    v[17] = act && a[2];
    v[16] = act && a[3];
    v[15] = (cson && c[10]) ^ c[4];
    v[14] = (cson && !c[10]) ^ c[4];
    v[13] = (act && a[5]) ^ c[5];
    v[12] = (act && a[6]) ^ c[6];
    v[11] = (ph == 1) ^ c[7];
    v[10] = !(ph == 2 && wr);
    v[9]  = !(ph == 2 && !wr);
    v[8]  = act && wr;
    v[7:0] = (act && wr) ? wb : 8'h00;
    return v;
  endfunction

  function automatic logic [18:0] act_vec();
    return {host_ready, nand_ale, nand_cle, nand_cs[1], nand_cs[0], nand_spare,
            nand_wp, nand_pre, nand_we_n, nand_re_n, nand_dq_oe, nand_dq_out};
  endfunction

  task automatic access(input logic [7:0] a, input bit we, input logic [31:0] wd,
                        input logic [7:0] base, input string tag, output logic [31:0] rd);
    bit win, en;
    int t;
    win = !a[7];
    en  = win && ctrl_m[0] && ctrl_m[20];
    t   = en ? (SL + (we ? P_WR : P_RD) * P_MUL + HL + RL) : 0;
    @(negedge clk);
    check(act_vec() == exp_vec(0, t, en, we, a[6:0], wd[7:0], ctrl_m), {tag, " idle pins"},
          32'(act_vec()), 32'(exp_vec(0, t, en, we, a[6:0], wd[7:0], ctrl_m)));
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = wd;
    for (int k = 1; k <= t + 1; k++) begin
      @(negedge clk);
      if (k == 1 && !win && we && a == 8'hB0) ctrl_m = wd & 32'h0010_05F3;
      nand_dq_in = base + 8'(k);
      check(act_vec() == exp_vec(k, t, en, we, a[6:0], wd[7:0], ctrl_m),
            $sformatf("%s cycle %0d", tag, k),
            32'(act_vec()), 32'(exp_vec(k, t, en, we, a[6:0], wd[7:0], ctrl_m)));
    end
    rd = host_rdata;
    host_req = 1'b0;
    if (en) cmplt_m = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_vec++; n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=completed");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] exp_b;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0;
    host_wdata = '0; nand_dq_in = '0; nand_rb = 2'b00;
    ctrl_m = '0; cmplt_m = 1'b0;
    repeat (3) @(negedge clk);
    // R1: pins at reset
    check(act_vec() == exp_vec(0, 0, 0, 0, '0, '0, '0), "R1 reset pins",
          32'(act_vec()), 32'(exp_vec(0, 0, 0, 0, '0, '0, '0)));
    rst_n = 1'b1;
    access(8'hB0, 0, 0, 0, "R1 ctrl read", rd);
    check(rd == 0, "R1 ctrl reset", rd, 0);
    access(8'hB4, 0, 0, 0, "R1 status read", rd);
    check(rd == 0, "R1 status reset", rd, 0);

    // R3: disabled window accesses
    access(8'h18, 1, 32'h70, 0, "R3 disabled write", rd);
    access(8'hB0, 1, 32'h1, 0, "R3 mode only", rd);
    access(8'h10, 0, 0, 8'h40, "R3 disabled read", rd);
    check(rd == 0, "R3 disabled read data", rd, 0);
    access(8'hB4, 0, 0, 0, "R8 status", rd);
    check(rd[3] == 1'b0, "R8 flag untouched by disabled access", rd, 0);

    // R2: writable mask
    access(8'hB0, 1, 32'hFFFF_FFFF, 0, "R2 write", rd);
    access(8'hB0, 0, 0, 0, "R2 read", rd);
    check(rd == 32'h0010_05F3, "R2 readback", rd, 32'h0010_05F3);

    // R4 R5 R6 R13: command, address, data write
    access(8'hB0, 1, 32'h0010_0001, 0, "R5 enable", rd);
    access(8'h18, 1, 32'h70, 0, "R4 command write", rd);
    access(8'h14, 1, 32'hA5, 0, "R4 address write", rd);
    access(8'h10, 1, 32'h3C, 0, "R6 data write", rd);

    // R7: read samples last wait cycle
    access(8'h10, 0, 0, 8'h20, "R7 data read", rd);
    exp_b = 8'h20 + 8'(SL + P_RD * P_MUL);
    check(rd == {24'b0, exp_b}, "R7 read data", rd, {24'b0, exp_b});

    // R8 R9: status
    nand_rb = 2'b01;
    access(8'hB4, 0, 0, 0, "R9 status", rd);
    check(rd == 32'h9, "R8 R9 flag set and rb0", rd, 32'h9);
    access(8'hB0, 1, 32'h0010_0101, 0, "R9 route", rd);
    access(8'hB4, 0, 0, 0, "R9 status2", rd);
    check(rd == 32'h8, "R9 rb1 selected", rd, 32'h8);
    nand_rb = 2'b10;
    access(8'hB4, 0, 0, 0, "R9 status3", rd);
    check(rd == 32'h9, "R9 rb1 high", rd, 32'h9);

    // R10 R13: polarities
    access(8'hB0, 1, 32'h0010_00F1, 0, "R10 pol", rd);
    access(8'h70, 1, 32'h5A, 0, "R10 inverted lines", rd);
    access(8'h0C, 0, 0, 8'h80, "R10 cle read", rd);

    // R11 R12: route and hold through recovery
    access(8'hB0, 1, 32'h0010_0403, 0, "R11 route", rd);
    access(8'h10, 0, 0, 8'h11, "R11 R12 read", rd);
    access(8'hB0, 1, 32'h0010_0013, 0, "R12 pol", rd);
    access(8'h7C, 1, 32'hC3, 0, "R4 R12 all lines", rd);
    access(8'hB0, 1, 32'h0000_0001, 0, "R3 ce off", rd);
    access(8'h7C, 1, 32'hC3, 0, "R3 ce off write", rd);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule